// File: doc/BRIEF.md
# CAN Bit-Time Stamp Counter

This block keeps a free-running 16-bit count of the bit times seen on a CAN bus. It does not count system clocks. The bit-timing logic sends it one strobe for every bit it recognizes, and the counter advances by one on each strobe. Firmware can read the live value at any time through a read-only register port. Writes aimed at that register are accepted on the bus and then discarded.

The counter also stamps messages. When a frame is sent or received successfully, the frame logic pulses a success strobe together with a 4-bit buffer index. The counter value at that moment is copied into the time-stamp slot of that buffer. A read index selects which slot appears on the stamp read port.

There is an optional resynchronisation feature. When the sync enable bit is set, a completed transfer on buffer 0 returns the counter to zero. This lets the nodes on the bus share a common time origin. Everything runs on one system clock, and the reset is asynchronous and active-low.

Top module: `can_bit_stamp`

## Requirements
- R1: The counter is 16 bits wide. A bit strobe taken at 0xFFFF gives 0x0000 on the next edge, with no saturation.
- R2: On each rising clock edge where `bit_tick` is high and no sync clear applies, the counter increases by exactly one. With neither a strobe nor a clear, it holds its value.
- R3: While `rst_n` is low, the counter and all 16 time-stamp slots read 0x0000. Counting starts from 0x0000 once reset is released.
- R4: When `sync_en` and `buf0_done` are both high at a clock edge, the counter is 0x0000 after that edge.
- R5: A `buf0_done` pulse while `sync_en` is low leaves the counter to count normally, as if the pulse were absent.
- R6: If a sync clear and a bit strobe arrive in the same cycle, the clear wins and the counter becomes 0x0000, not 0x0001.
- R7: A `frame_ok` pulse copies the counter value from before that edge into slot `frame_idx` (index 0 to 15). All other slots keep their contents.
- R8: If a capture into slot 0 coincides with a sync clear, the slot receives the value from before the clear, not zero.
- R9: A write on the register port (`cnt_wr_en` with any `cnt_wr_data`) has no effect on the counter value.
- R10: `cnt_rd_data` shows the counter register without delay. `ts_rd_data` shows slot `ts_rd_idx` combinationally, so a capture becomes visible right after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per recognized bus bit |
| sync_en | input | 1 | Enables clearing of the counter on a buffer-0 transfer |
| buf0_done | input | 1 | Buffer-0 transfer-complete pulse |
| frame_ok | input | 1 | Frame sent or received successfully |
| frame_idx | input | 4 | Buffer that handled the frame, valid with `frame_ok` |
| cnt_wr_en | input | 1 | CPU write strobe to the counter register (discarded) |
| cnt_wr_data | input | 16 | CPU write data (discarded) |
| cnt_rd_data | output | 16 | Live counter value |
| ts_rd_idx | input | 4 | Slot selected for stamp readout |
| ts_rd_data | output | 16 | Time stamp held in the selected slot |

## Verification
The bench drives the counter all the way around from 0xFFFF. A design with a saturating or wider counter would read 0xFFFF or a stray carry there instead of zero. It applies a sync clear and a bit strobe in the same cycle. A design that gave the increment priority would show 0x0001. It captures into buffer 0 in the same cycle as a clear. A design that sampled the counter after the clear would store zero instead of the old count. It also pulses `buf0_done` with sync disabled and writes the counter register through the CPU port. A design that let either of these leak through would lose or corrupt the count.

// File: rtl/can_bit_stamp_pkg.sv
package can_bit_stamp_pkg;
   localparam int unsigned STAMP_W_DEF  = 16;
   localparam int unsigned NUM_SLOT_DEF = 16;

   typedef enum logic [1:0] {
      CNT_HOLD  = 2'd0,
      CNT_STEP  = 2'd1,
      CNT_CLEAR = 2'd2
   } cnt_op_e;
endpackage

// File: rtl/can_bit_stamp_counter.sv
module can_bit_stamp_counter
   import can_bit_stamp_pkg::*;
#(
   parameter int unsigned CNT_W        = STAMP_W_DEF,
   parameter bit          SYNC_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             sync_en,
   input  logic             buf0_done,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   initial begin
      assert (CNT_W >= 2) else $error("counter width must be at least 2");
   end

   logic    clr_req;
   cnt_op_e op;

   generate
      if (SYNC_SUPPORT) begin : g_sync
         assign clr_req = sync_en & buf0_done;
      end else begin : g_nosync
         logic unused_sync;
         assign unused_sync = sync_en ^ buf0_done;
         assign clr_req     = 1'b0;
      end
   endgenerate

   always_comb begin
      if (clr_req)       op = CNT_CLEAR;
      else if (bit_tick) op = CNT_STEP;
      else               op = CNT_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (op)
            CNT_CLEAR: cnt_q <= '0;
            CNT_STEP:  cnt_q <= cnt_q + ONE;
            default:   cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/can_bit_stamp_store.sv
module can_bit_stamp_store
   import can_bit_stamp_pkg::*;
#(
   parameter int unsigned CNT_W    = STAMP_W_DEF,
   parameter int unsigned NUM_SLOT = NUM_SLOT_DEF,
   parameter int unsigned IDX_W    = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [IDX_W-1:0] cap_idx,
   input  logic [CNT_W-1:0] cap_val,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_val
);
   localparam int unsigned SPAN = 1 << IDX_W;

   initial begin
      assert (NUM_SLOT >= 1 && NUM_SLOT <= SPAN)
         else $error("slot count does not fit the index width");
   end

   logic [CNT_W-1:0] slot_q [NUM_SLOT];

   genvar g;
   generate
      for (g = 0; g < NUM_SLOT; g++) begin : g_slot
         logic hit;
         assign hit = cap_en && (cap_idx == IDX_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   slot_q[g] <= '0;
            else if (hit) slot_q[g] <= cap_val;
         end
      end

      if (NUM_SLOT == SPAN) begin : g_full
         assign rd_val = slot_q[rd_idx];
      end else begin : g_part
         assign rd_val = (32'(rd_idx) < NUM_SLOT) ? slot_q[rd_idx] : '0;
      end
   endgenerate
endmodule

// File: rtl/can_bit_stamp_regport.sv
module can_bit_stamp_regport
   import can_bit_stamp_pkg::*;
#(
   parameter int unsigned CNT_W = STAMP_W_DEF
) (
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [CNT_W-1:0] live_cnt,
   output logic [CNT_W-1:0] rd_data
);
   logic unused_wr;
   assign unused_wr = wr_en ^ (^wr_data);
   assign rd_data   = live_cnt;
endmodule

// File: rtl/can_bit_stamp.sv
module can_bit_stamp
   import can_bit_stamp_pkg::*;
#(
   parameter int unsigned CNT_W        = STAMP_W_DEF,
   parameter int unsigned NUM_SLOT     = NUM_SLOT_DEF,
   parameter bit          SYNC_SUPPORT = 1'b1,
   parameter int unsigned IDX_W        = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             sync_en,
   input  logic             buf0_done,
   input  logic             frame_ok,
   input  logic [IDX_W-1:0] frame_idx,
   input  logic             cnt_wr_en,
   input  logic [CNT_W-1:0] cnt_wr_data,
   output logic [CNT_W-1:0] cnt_rd_data,
   input  logic [IDX_W-1:0] ts_rd_idx,
   output logic [CNT_W-1:0] ts_rd_data
);
   logic [CNT_W-1:0] cnt_q;

   can_bit_stamp_counter #(.CNT_W(CNT_W), .SYNC_SUPPORT(SYNC_SUPPORT)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .sync_en   (sync_en),
      .buf0_done (buf0_done),
      .cnt_q     (cnt_q)
   );

   can_bit_stamp_store #(.CNT_W(CNT_W), .NUM_SLOT(NUM_SLOT), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (frame_ok),
      .cap_idx (frame_idx),
      .cap_val (cnt_q),
      .rd_idx  (ts_rd_idx),
      .rd_val  (ts_rd_data)
   );

   can_bit_stamp_regport #(.CNT_W(CNT_W)) u_reg (
      .wr_en    (cnt_wr_en),
      .wr_data  (cnt_wr_data),
      .live_cnt (cnt_q),
      .rd_data  (cnt_rd_data)
   );
endmodule

// File: rtl/can_bit_stamp_chk.sv
module can_bit_stamp_chk #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_tick,
   input logic             sync_en,
   input logic             buf0_done,
   input logic             frame_ok,
   input logic [IDX_W-1:0] frame_idx,
   input logic             cnt_wr_en,
   input logic [CNT_W-1:0] cnt,
   input logic [IDX_W-1:0] ts_rd_idx,
   input logic [CNT_W-1:0] ts_rd_data
);
   logic clr;
   assign clr = sync_en & buf0_done;

   assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && !clr && cnt == {CNT_W{1'b1}}) |=> (cnt == '0));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && !clr) |=> $stable(cnt));

   assert_reset_R3: assert property (@(posedge clk)
      !rst_n |-> (cnt == '0));

   assert_sync_clear_R4_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   assert_capture_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok && ts_rd_idx == frame_idx) |=>
         ((ts_rd_idx != $past(ts_rd_idx)) || (ts_rd_data == $past(cnt))));

   assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_en && !bit_tick && !clr) |=> $stable(cnt));
endmodule

bind can_bit_stamp can_bit_stamp_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_tick   (bit_tick),
   .sync_en    (sync_en),
   .buf0_done  (buf0_done),
   .frame_ok   (frame_ok),
   .frame_idx  (frame_idx),
   .cnt_wr_en  (cnt_wr_en),
   .cnt        (cnt_rd_data),
   .ts_rd_idx  (ts_rd_idx),
   .ts_rd_data (ts_rd_data)
);

// File: tb/can_bit_stamp_tb_top.sv
module can_bit_stamp_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_tick = 1'b0;
   logic        sync_en = 1'b0;
   logic        buf0_done = 1'b0;
   logic        frame_ok = 1'b0;
   logic [3:0]  frame_idx = '0;
   logic        cnt_wr_en = 1'b0;
   logic [15:0] cnt_wr_data = '0;
   logic [15:0] cnt_rd_data;
   logic [3:0]  ts_rd_idx = '0;
   logic [15:0] ts_rd_data;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [15:0] exp_cnt = '0;
   logic [15:0] exp_ts [16];

   typedef struct packed {
      logic [15:0] cnt;
      logic [15:0] ts;
      logic [3:0]  idx;
   } exp_item_t;

   exp_item_t exp_q [$];
   string     req_q [$];

   always #4 clk = ~clk;

   can_bit_stamp dut_i (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sync_en(sync_en),
      .buf0_done(buf0_done), .frame_ok(frame_ok), .frame_idx(frame_idx),
      .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
      .cnt_rd_data(cnt_rd_data), .ts_rd_idx(ts_rd_idx), .ts_rd_data(ts_rd_data)
   );

   task automatic check(input string rq, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic step(input logic tk, input logic sy, input logic dn,
                       input logic fo, input logic [3:0] fi, input logic we,
                       input logic [3:0] ri, input string rq);
      exp_item_t it;
      @(negedge clk);
      bit_tick    = tk;
      sync_en     = sy;
      buf0_done   = dn;
      frame_ok    = fo;
      frame_idx   = fi;
      cnt_wr_en   = we;
      cnt_wr_data = exp_cnt ^ 16'h5A3C;
      ts_rd_idx   = ri;
      if (fo) exp_ts[fi] = exp_cnt;
      if (sy && dn)  exp_cnt = '0;
      else if (tk)   exp_cnt = exp_cnt + 16'd1;
      it.cnt = exp_cnt;
      it.ts  = exp_ts[ri];
      it.idx = ri;
      exp_q.push_back(it);
      req_q.push_back(rq);
   endtask

   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         exp_item_t it;
         string     rq;
         it = exp_q.pop_front();
         rq = req_q.pop_front();
         check(rq, "counter", cnt_rd_data, it.cnt);
         check(rq, $sformatf("slot %0d", it.idx), ts_rd_data, it.ts);
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) exp_ts[i] = '0;
      // R3: reset state
      #20;
      check("R3", "counter in reset", cnt_rd_data, 16'h0000);
      for (int i = 0; i < 16; i += 5) begin
         ts_rd_idx = i[3:0];
         #1;
         check("R3", "slot in reset", ts_rd_data, 16'h0000);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R2: counting and holding
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 0, 0, 0, "R2");
      step(1, 0, 0, 0, 0, 0, 0, "R2");
      // R9: writes ignored, with and without a strobe
      step(0, 0, 0, 0, 0, 1, 0, "R9");
      step(1, 0, 0, 0, 0, 1, 0, "R9");
      step(0, 0, 0, 0, 0, 0, 0, "R9");
      // R5: buf0_done without sync enable
      step(1, 0, 1, 0, 0, 0, 0, "R5");
      step(0, 0, 1, 0, 0, 0, 0, "R5");
      // R7/R10: captures into several slots, neighbours untouched
      step(0, 0, 0, 1, 5, 0, 5, "R7");
      step(1, 0, 0, 0, 0, 0, 5, "R10");
      step(1, 0, 0, 1, 15, 0, 6, "R7");
      step(0, 0, 0, 0, 0, 0, 15, "R7");
      step(1, 0, 0, 1, 3, 0, 3, "R7");
      step(0, 0, 0, 0, 0, 0, 4, "R7");
      // R4: sync clear
      step(0, 1, 1, 0, 0, 0, 0, "R4");
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0, 0, "R2");
      // R6: clear beats strobe
      step(1, 1, 1, 0, 0, 0, 0, "R6");
      for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0, "R2");
      // R8: buffer-0 capture coinciding with clear keeps the old value
      step(1, 1, 1, 1, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 0, 0, 5, "R7");
      // R1: run to 0xFFFF and wrap
      step(0, 1, 1, 0, 0, 0, 0, "R4");
      for (int i = 0; i < 65535; i++) step(1, 0, 0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 1, 9, 0, 9, "R1");
      step(1, 0, 0, 0, 0, 0, 9, "R1");
      step(1, 0, 0, 0, 0, 0, 9, "R1");
      step(0, 0, 0, 0, 0, 0, 9, "R1");
      // R3: asynchronous reset mid-run
      @(negedge clk);
      bit_tick = 1'b0;
      repeat (3) @(posedge clk);
      #3;
      rst_n = 1'b0;
      #1;
      check("R3", "counter after async reset", cnt_rd_data, 16'h0000);
      ts_rd_idx = 4'd9;
      #1;
      check("R3", "slot after async reset", ts_rd_data, 16'h0000);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule